// File: doc/BRIEF.md
# Flash Command Sequence Interpreter

This block is the write-command front end of a byte-programmable, sector-erasable flash store. It watches an asynchronous parallel bus made of chip-enable, write-enable and output-enable. It turns the strobes into clean bus write events, recognises the unlock and command writes for a byte program and for a sector erase, and applies them to a small behavioural array. A read is served straight from the array whenever the bus asks for one.

A program can only clear bits. An erase fills one 512-byte sector with FFh, one byte per clock, during a busy window. A 16 KB boot region can be write-protected by a level input. The region sits at the top of the address space by default and at the bottom when a parameter selects it. The block has no reset command. A broken or unfinished sequence either waits for more writes or is abandoned by any write that fits no command.

The storage model holds only a few sectors so that it stays small. Sector numbers fold onto the modelled sectors. The full bus address is still used for command decoding and for the boot-region check.

Top module: `flash_cmd_seq`

## Requirements
- R1: While `rstN` is low and right after it rises, `busy` is 0, `dataOe` is 0 and the sequencer is in read mode.
- R2: `dataOe` is 1 only when `ceN`=0, `oeN`=0 and `weN`=1. `dataOut` then shows the stored byte at `addr`, and is 00h whenever `dataOe` is 0.
- R3: With `ceN`=1 (standby) or `oeN`=1, `dataOe` is 0 and `dataOut` is 00h, whatever the other inputs do.
- R4: A byte program is four bus writes in this order: AAh to 5555h, 55h to 2AAAh, A0h to 5555h, then the data to the target address.
- R5: A program stores the old byte ANDed with the new data, so it can clear bits but never set them.
- R6: A sector erase is six bus writes in this order: AAh to 5555h, 55h to 2AAAh, 80h to 5555h, AAh to 5555h, 55h to 2AAAh, then 30h to any address in the sector. The erase sets all 512 bytes of that sector to FFh and leaves every other sector unchanged.
- R7: While `lockBoot`=1, a program or erase whose final write falls in the boot region is dropped. The boot region is the 16 KB at addresses 3C000h to 3FFFFh with `BOOT_AT_TOP`=1, or 00000h to 03FFFh otherwise. A dropped command produces no busy window, and the block is back in read mode at once. Writes outside the region are still accepted.
- R8: Any write that fits no step of the current sequence, such as FFh to 5555h, returns the sequencer to read mode. A following setup code alone then does nothing.
- R9: A partial sequence has no timeout. After any idle time the remaining writes still complete it.
- R10: A write cycle may be led by either strobe. The address is taken when the second of `ceN`/`weN` falls, and the data is taken when the first of them rises. Bus values before or after those points are ignored.
- R11: An accepted program holds `busy` high for exactly `PROG_BUSY` clocks. An accepted erase holds it high for max(`ERASE_BUSY`, 512) clocks.
- R12: Bus writes that finish while `busy` is high are ignored, and the sequencer is in read mode when `busy` falls.
- R13: Storage keeps 2^`MODEL_SECT_W` sectors. A bus address whose sector number differs only above those bits reaches the same byte, so 00810h and 3C010h alias 00010h by default.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low asynchronous reset |
| ceN | input | 1 | Chip enable, active low |
| weN | input | 1 | Write enable, active low |
| oeN | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Byte address on the bus |
| dataIn | input | 8 | Write data from the bus |
| lockBoot | input | 1 | 1 protects the boot region against program and erase |
| dataOut | output | 8 | Read data, 00h when not driven |
| dataOe | output | 1 | 1 when the block drives the read data onto the bus |
| busy | output | 1 | High during the fixed program or erase window |

## Verification
A sequencer stuck in a wrong state shows up at the first byte read after the command that follows. If it is one step behind, a valid sequence leaves the byte unchanged. If it is one step ahead, a stray target write alters a byte that should have kept its value. For that reason every sequence case ends with a read-back of the target byte and of a neighbour. A wrong busy count or a missed boot-lock decision shows within one command window, as a busy pulse of the wrong length or a busy pulse where none is expected. A wrong latch edge for address or data puts the deliberately different out-of-window bus value into the array, and the next read of that byte shows it.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  // Strobes from the sequence controller to the array datapath.
  typedef struct packed {
    logic prog;        // AND the captured byte into the captured address
    logic eraseStart;  // capture the sector to clear and rewind the walker
    logic eraseStep;   // write FFh at the walker position and advance
  } arr_op_t;

  typedef enum logic [2:0] {
    SEQ_READ,
    SEQ_KEY1,
    SEQ_KEY2,
    SEQ_PROG_DATA,
    SEQ_ERASE_SETUP,
    SEQ_ERASE_KEY1,
    SEQ_ERASE_KEY2,
    SEQ_BUSY
  } seq_state_t;

  localparam logic [7:0]  KEY_FIRST       = 8'hAA;
  localparam logic [7:0]  KEY_SECOND      = 8'h55;
  localparam logic [7:0]  OP_PROGRAM      = 8'hA0;
  localparam logic [7:0]  OP_ERASE_SETUP  = 8'h80;
  localparam logic [7:0]  OP_ERASE_SECTOR = 8'h30;
  localparam logic [7:0]  ERASED_BYTE     = 8'hFF;
  localparam logic [15:0] KEY_ADDR_FIRST  = 16'h5555;
  localparam logic [15:0] KEY_ADDR_SECOND = 16'h2AAA;

endpackage

// File: rtl/flash_array_dp.sv
module flash_array_dp
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W       = 18,
  parameter int SECTOR_W     = 9,
  parameter int MODEL_SECT_W = 2,
  parameter int SYNC_STAGES  = 2
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     ceN,
  input  logic                     weN,
  input  logic [ADDR_W-1:0]        busAddr,
  input  logic [7:0]               busData,
  input  logic [SECTOR_W+MODEL_SECT_W-1:0] rdIdx,
  input  arr_op_t                  op,
  output logic                     wrValid,
  output logic [ADDR_W-1:0]        wrAddr,
  output logic [7:0]               wrData,
  output logic [7:0]               rdData
);

  localparam int MEM_W     = SECTOR_W + MODEL_SECT_W;
  localparam int MEM_BYTES = 1 << MEM_W;
  localparam int BUS_W     = ADDR_W + 10;
  localparam logic [BUS_W-1:0] BUS_IDLE = {2'b11, {(BUS_W-2){1'b0}}};

  // The whole bus bundle passes through the same synchroniser depth, so
  // strobes, address and data stay aligned with each other.
  logic [SYNC_STAGES-1:0][BUS_W-1:0] syncPipe;
  logic [BUS_W-1:0] busNow;
  logic [BUS_W-1:0] busSync;

  assign busNow  = {ceN, weN, busAddr, busData};
  assign busSync = syncPipe[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < SYNC_STAGES; s++) syncPipe[s] <= BUS_IDLE;
    end else begin
      syncPipe[0] <= busNow;
      for (int s = 1; s < SYNC_STAGES; s++) syncPipe[s] <= syncPipe[s-1];
    end
  end

  logic              syncCeN;
  logic              syncWeN;
  logic [ADDR_W-1:0] syncAddr;
  logic [7:0]        syncData;
  logic              strobeOn;
  logic              strobeOnQ;
  logic [ADDR_W-1:0] addrLat;
  logic [7:0]        dataLat;

  assign syncCeN  = busSync[BUS_W-1];
  assign syncWeN  = busSync[BUS_W-2];
  assign syncAddr = busSync[BUS_W-3 -: ADDR_W];
  assign syncData = busSync[7:0];

  // A write cycle is the window in which both strobes are low.
  assign strobeOn = !syncCeN && !syncWeN;

  // The address is taken when the window opens (the later falling strobe).
  // The data is tracked while the window is open, so it holds the value
  // present at the earlier rising strobe.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      strobeOnQ <= 1'b0;
      addrLat   <= '0;
      dataLat   <= '0;
    end else begin
      strobeOnQ <= strobeOn;
      if (strobeOn && !strobeOnQ) addrLat <= syncAddr;
      if (strobeOn)               dataLat <= syncData;
    end
  end

  assign wrValid = strobeOnQ && !strobeOn;
  assign wrAddr  = addrLat;
  assign wrData  = dataLat;

  // Erase walker: one byte per step across the captured sector.
  logic [MODEL_SECT_W-1:0] eraseSect;
  logic [SECTOR_W-1:0]     walkPos;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      eraseSect <= '0;
      walkPos   <= '0;
    end else if (op.eraseStart) begin
      eraseSect <= addrLat[MEM_W-1:SECTOR_W];
      walkPos   <= '0;
    end else if (op.eraseStep) begin
      walkPos   <= walkPos + 1'b1;
    end
  end

  // Storage model: nonvolatile contents, so no reset.
  logic [7:0]       mem [MEM_BYTES];
  logic [MEM_W-1:0] progIdx;
  logic [MEM_W-1:0] eraseIdx;

  assign progIdx  = addrLat[MEM_W-1:0];
  assign eraseIdx = {eraseSect, walkPos};

  always_ff @(posedge clk) begin
    if (op.prog)      mem[progIdx]  <= mem[progIdx] & dataLat;
    if (op.eraseStep) mem[eraseIdx] <= ERASED_BYTE;
  end

  assign rdData = mem[rdIdx];

endmodule

// File: rtl/flash_seq_ctrl.sv
module flash_seq_ctrl
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W      = 18,
  parameter int SECTOR_W    = 9,
  parameter int BOOT_W      = 14,
  parameter bit BOOT_AT_TOP = 1'b1,
  parameter int PROG_BUSY   = 16,
  parameter int ERASE_BUSY  = 600
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              lockBoot,
  input  logic              wrValid,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [7:0]        wrData,
  output arr_op_t           op,
  output logic              busy
);

  localparam int SECT_BYTES = 1 << SECTOR_W;
  localparam int ERASE_LEN  = (ERASE_BUSY > SECT_BYTES) ? ERASE_BUSY : SECT_BYTES;
  localparam int LEN_MAX    = (ERASE_LEN > PROG_BUSY) ? ERASE_LEN : PROG_BUSY;
  localparam int CNT_W      = $clog2(LEN_MAX + 1);
  localparam logic [ADDR_W-1:0] ADDR_K1 = ADDR_W'(KEY_ADDR_FIRST);
  localparam logic [ADDR_W-1:0] ADDR_K2 = ADDR_W'(KEY_ADDR_SECOND);

  seq_state_t        state, nextState;
  logic [CNT_W-1:0]  cnt;
  logic [CNT_W-1:0]  limit;
  logic              eraseMode;
  logic              loadProg;
  logic              loadErase;
  logic              inBoot;
  logic              blocked;
  logic              isKey1;
  logic              isKey2;
  logic              isProgSetup;
  logic              isEraseSetup;

  // Boot region position is a build-time choice.
  generate
    if (BOOT_AT_TOP) begin : g_boot_top
      assign inBoot = &wrAddr[ADDR_W-1:BOOT_W];
    end else begin : g_boot_bottom
      assign inBoot = ~|wrAddr[ADDR_W-1:BOOT_W];
    end
  endgenerate

  assign blocked      = lockBoot && inBoot;
  assign isKey1       = (wrAddr == ADDR_K1) && (wrData == KEY_FIRST);
  assign isKey2       = (wrAddr == ADDR_K2) && (wrData == KEY_SECOND);
  assign isProgSetup  = (wrAddr == ADDR_K1) && (wrData == OP_PROGRAM);
  assign isEraseSetup = (wrAddr == ADDR_K1) && (wrData == OP_ERASE_SETUP);

  always_comb begin
    nextState     = state;
    loadProg      = 1'b0;
    loadErase     = 1'b0;
    op            = '0;
    unique case (state)
      SEQ_READ: begin
        if (wrValid && isKey1) nextState = SEQ_KEY1;
      end
      SEQ_KEY1: begin
        if (wrValid) nextState = isKey2 ? SEQ_KEY2 : SEQ_READ;
      end
      SEQ_KEY2: begin
        if (wrValid) begin
          if (isProgSetup)       nextState = SEQ_PROG_DATA;
          else if (isEraseSetup) nextState = SEQ_ERASE_SETUP;
          else                   nextState = SEQ_READ;
        end
      end
      SEQ_PROG_DATA: begin
        if (wrValid) begin
          if (blocked) begin
            nextState = SEQ_READ;
          end else begin
            op.prog   = 1'b1;
            loadProg  = 1'b1;
            nextState = SEQ_BUSY;
          end
        end
      end
      SEQ_ERASE_SETUP: begin
        if (wrValid) nextState = isKey1 ? SEQ_ERASE_KEY1 : SEQ_READ;
      end
      SEQ_ERASE_KEY1: begin
        if (wrValid) nextState = isKey2 ? SEQ_ERASE_KEY2 : SEQ_READ;
      end
      SEQ_ERASE_KEY2: begin
        if (wrValid) begin
          if ((wrData == OP_ERASE_SECTOR) && !blocked) begin
            op.eraseStart = 1'b1;
            loadErase     = 1'b1;
            nextState     = SEQ_BUSY;
          end else begin
            nextState = SEQ_READ;
          end
        end
      end
      SEQ_BUSY: begin
        // Bus writes are dropped for the whole window.
        op.eraseStep = eraseMode && (cnt < CNT_W'(SECT_BYTES));
        if (cnt == limit) nextState = SEQ_READ;
      end
      default: nextState = SEQ_READ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= SEQ_READ;
      cnt       <= '0;
      limit     <= '0;
      eraseMode <= 1'b0;
    end else begin
      state <= nextState;
      if (loadProg) begin
        cnt       <= '0;
        limit     <= CNT_W'(PROG_BUSY - 1);
        eraseMode <= 1'b0;
      end else if (loadErase) begin
        cnt       <= '0;
        limit     <= CNT_W'(ERASE_LEN - 1);
        eraseMode <= 1'b1;
      end else if (state == SEQ_BUSY) begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assign busy = (state == SEQ_BUSY);

endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W       = 18,
  parameter int SECTOR_W     = 9,
  parameter int BOOT_W       = 14,
  parameter bit BOOT_AT_TOP  = 1'b1,
  parameter int MODEL_SECT_W = 2,
  parameter int SYNC_STAGES  = 2,
  parameter int PROG_BUSY    = 16,
  parameter int ERASE_BUSY   = 600
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ceN,
  input  logic              weN,
  input  logic              oeN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        dataIn,
  input  logic              lockBoot,
  output logic [7:0]        dataOut,
  output logic              dataOe,
  output logic              busy
);

  localparam int MEM_W = SECTOR_W + MODEL_SECT_W;

  arr_op_t           arrOp;
  logic              wrValid;
  logic [ADDR_W-1:0] wrAddr;
  logic [7:0]        wrData;
  logic [7:0]        rdData;

  flash_array_dp #(
    .ADDR_W      (ADDR_W),
    .SECTOR_W    (SECTOR_W),
    .MODEL_SECT_W(MODEL_SECT_W),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .ceN     (ceN),
    .weN     (weN),
    .busAddr (addr),
    .busData (dataIn),
    .rdIdx   (addr[MEM_W-1:0]),
    .op      (arrOp),
    .wrValid (wrValid),
    .wrAddr  (wrAddr),
    .wrData  (wrData),
    .rdData  (rdData)
  );

  flash_seq_ctrl #(
    .ADDR_W     (ADDR_W),
    .SECTOR_W   (SECTOR_W),
    .BOOT_W     (BOOT_W),
    .BOOT_AT_TOP(BOOT_AT_TOP),
    .PROG_BUSY  (PROG_BUSY),
    .ERASE_BUSY (ERASE_BUSY)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .lockBoot(lockBoot),
    .wrValid (wrValid),
    .wrAddr  (wrAddr),
    .wrData  (wrData),
    .op      (arrOp),
    .busy    (busy)
  );

  // Read path follows the pins directly; either enable going high
  // releases the bus at once.
  assign dataOe  = !ceN && !oeN && weN;
  assign dataOut = dataOe ? rdData : 8'h00;

endmodule

// File: rtl/flash_cmd_chk.sv
module flash_cmd_chk
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W      = 18,
  parameter int SECTOR_W    = 9,
  parameter int BOOT_W      = 14,
  parameter bit BOOT_AT_TOP = 1'b1,
  parameter int PROG_BUSY   = 16,
  parameter int ERASE_BUSY  = 600
) (
  input logic              clk,
  input logic              rstN,
  input logic              ceN,
  input logic              weN,
  input logic              lockBoot,
  input logic              dataOe,
  input logic [7:0]        dataOut,
  input logic              busy,
  input arr_op_t           op,
  input logic [ADDR_W-1:0] tgtAddr
);

  localparam int SECT_BYTES = 1 << SECTOR_W;
  localparam int ERASE_LEN  = (ERASE_BUSY > SECT_BYTES) ? ERASE_BUSY : SECT_BYTES;

  logic       tgtInBoot;
  logic [31:0] runLen;

  assign tgtInBoot = BOOT_AT_TOP ? (&tgtAddr[ADDR_W-1:BOOT_W])
                                 : (~|tgtAddr[ADDR_W-1:BOOT_W]);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     runLen <= '0;
    else if (busy) runLen <= runLen + 1;
    else           runLen <= '0;
  end

  assert_standby_quiet_R3: assert property (@(posedge clk) disable iff (!rstN)
    ceN |-> (!dataOe && dataOut == 8'h00));

  assert_no_drive_in_write_R2: assert property (@(posedge clk) disable iff (!rstN)
    !weN |-> !dataOe);

  assert_busy_blocks_cmds_R12: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (!op.prog && !op.eraseStart));

  assert_lock_honoured_R7: assert property (@(posedge clk) disable iff (!rstN)
    ((op.prog || op.eraseStart) && lockBoot) |-> !tgtInBoot);

  assert_erase_inside_busy_R6: assert property (@(posedge clk) disable iff (!rstN)
    op.eraseStep |-> busy);

  assert_accept_starts_busy_R4: assert property (@(posedge clk) disable iff (!rstN)
    (op.prog || op.eraseStart) |=> busy);

  assert_busy_length_R11: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> (runLen == PROG_BUSY || runLen == ERASE_LEN));

endmodule

bind flash_cmd_seq flash_cmd_chk #(
  .ADDR_W     (ADDR_W),
  .SECTOR_W   (SECTOR_W),
  .BOOT_W     (BOOT_W),
  .BOOT_AT_TOP(BOOT_AT_TOP),
  .PROG_BUSY  (PROG_BUSY),
  .ERASE_BUSY (ERASE_BUSY)
) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .ceN     (ceN),
  .weN     (weN),
  .lockBoot(lockBoot),
  .dataOe  (dataOe),
  .dataOut (dataOut),
  .busy    (busy),
  .op      (arrOp),
  .tgtAddr (wrAddr)
);

// File: tb/tb_flash_cmd_seq.sv
module tb_flash_cmd_seq;

  localparam int AW        = 18;
  localparam int PROG_LEN  = 12;
  localparam int ERASE_LEN = 520;

  logic          clk = 1'b0;
  logic          rstN;
  logic          ceN, weN, oeN;
  logic [AW-1:0] addr;
  logic [7:0]    dataIn;
  logic          lockBoot;
  logic [7:0]    dataOut;
  logic          dataOe;
  logic          busy;

  always #5 clk = ~clk;

  flash_cmd_seq #(
    .ADDR_W    (AW),
    .PROG_BUSY (PROG_LEN),
    .ERASE_BUSY(ERASE_LEN)
  ) dut (
    .clk(clk), .rstN(rstN), .ceN(ceN), .weN(weN), .oeN(oeN),
    .addr(addr), .dataIn(dataIn), .lockBoot(lockBoot),
    .dataOut(dataOut), .dataOe(dataOe), .busy(busy)
  );

  int nChecks = 0;
  int nFail   = 0;

  typedef struct {
    logic [AW-1:0] where;
    logic [7:0]    exp;
    string         tag;
  } rd_item_t;

  rd_item_t sbq[$];

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Scoreboard monitor: compares each queued read once the bus is stable.
  initial begin
    forever begin
      @(negedge clk);
      if (sbq.size() > 0) begin
        rd_item_t it;
        it = sbq.pop_front();
        nChecks++;
        if (dataOe !== 1'b1 || dataOut !== it.exp) begin
          nFail++;
          $display("FAIL %s @%05h: actual oe=%0b data=%02h expected oe=1 data=%02h",
                   it.tag, it.where, dataOe, dataOut, it.exp);
        end
      end
    end
  end

  // Busy-window monitor: length of the most recent pulse and pulse count.
  int runCur   = 0;
  int lastRun  = 0;
  int busyRuns = 0;
  initial begin
    forever begin
      @(negedge clk);
      if (busy === 1'b1) runCur++;
      else if (runCur > 0) begin
        lastRun = runCur;
        busyRuns++;
        runCur = 0;
      end
    end
  end

  // Driver: a read pushes its expectation into the scoreboard.
  task automatic readExp(input logic [AW-1:0] a, input logic [7:0] e, input string tag);
    rd_item_t it;
    @(negedge clk);
    addr = a; ceN = 1'b0; oeN = 1'b0; weN = 1'b1;
    @(posedge clk);
    it.where = a; it.exp = e; it.tag = tag;
    sbq.push_back(it);
    @(negedge clk);
    @(negedge clk);
    ceN = 1'b1; oeN = 1'b1;
  endtask

  // One bus write. ceLead=1: the write-enable falls first and rises last, so
  // chip-enable controls the cycle; ceLead=0 is the mirror case. Junk values
  // surround the latch points.
  task automatic busWrite(input logic [AW-1:0] a, input logic [7:0] d, input bit ceLead);
    logic [AW-1:0] junkA;
    junkA = a ^ 18'h00F0F;
    @(negedge clk);
    addr = junkA; dataIn = ~d; oeN = 1'b1;
    if (ceLead) weN = 1'b0; else ceN = 1'b0;
    repeat (4) @(negedge clk);
    addr = a;
    repeat (2) @(negedge clk);
    if (ceLead) ceN = 1'b0; else weN = 1'b0;
    repeat (4) @(negedge clk);
    addr = junkA; dataIn = d;
    repeat (4) @(negedge clk);
    if (ceLead) ceN = 1'b1; else weN = 1'b1;
    @(negedge clk);
    dataIn = ~d;
    repeat (3) @(negedge clk);
    ceN = 1'b1; weN = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic cmdProgram(input logic [AW-1:0] a, input logic [7:0] d, input bit ceLead);
    busWrite(18'h05555, 8'hAA, ceLead);
    busWrite(18'h02AAA, 8'h55, ceLead);
    busWrite(18'h05555, 8'hA0, ceLead);
    busWrite(a, d, ceLead);
  endtask

  task automatic cmdErase(input logic [AW-1:0] a);
    busWrite(18'h05555, 8'hAA, 1'b0);
    busWrite(18'h02AAA, 8'h55, 1'b0);
    busWrite(18'h05555, 8'h80, 1'b0);
    busWrite(18'h05555, 8'hAA, 1'b0);
    busWrite(18'h02AAA, 8'h55, 1'b0);
    busWrite(a, 8'h30, 1'b0);
  endtask

  task automatic waitIdle();
    repeat (4) @(negedge clk);
    while (busy === 1'b1) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++;
    nFail++;
    $display("FAIL watchdog: actual hung expected finished");
    finishRun();
  end

  initial begin
    int runsBefore;
    rstN = 1'b0; ceN = 1'b1; weN = 1'b1; oeN = 1'b1;
    addr = '0; dataIn = '0; lockBoot = 1'b0;
    repeat (4) @(negedge clk);
    chk("R1 busy in reset", busy, 1'b0);
    chk("R1 oe in reset", dataOe, 1'b0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 busy after reset", busy, 1'b0);

    // R3: standby and output disable
    oeN = 1'b0; ceN = 1'b1;
    @(negedge clk);
    chk("R3 standby oe", dataOe, 1'b0);
    chk("R3 standby data", dataOut, 8'h00);
    oeN = 1'b1; ceN = 1'b0;
    @(negedge clk);
    chk("R3 oeN high", dataOe, 1'b0);
    ceN = 1'b1;

    // R6 / R11: erase two sectors, check the busy length
    runsBefore = busyRuns;
    cmdErase(18'h00000);
    waitIdle();
    chk("R11 erase pulse count", busyRuns, runsBefore + 1);
    chk("R11 erase length", lastRun, ERASE_LEN);
    readExp(18'h00000, 8'hFF, "R6 erase first byte");
    readExp(18'h001FF, 8'hFF, "R6 erase last byte");
    readExp(18'h00100, 8'hFF, "R6 erase middle");
    cmdErase(18'h00234);
    waitIdle();
    readExp(18'h00210, 8'hFF, "R6 erase sector1");

    // R4 / R5 / R10: program with both strobe orders
    runsBefore = busyRuns;
    cmdProgram(18'h00010, 8'h3C, 1'b0);
    waitIdle();
    chk("R11 program length", lastRun, PROG_LEN);
    chk("R4 program pulse", busyRuns, runsBefore + 1);
    readExp(18'h00010, 8'h3C, "R4 R10 program we-led");
    cmdProgram(18'h00010, 8'hF0, 1'b1);
    waitIdle();
    readExp(18'h00010, 8'h30, "R5 R10 and-merge ce-led");
    readExp(18'h00011, 8'hFF, "R4 neighbour untouched");
    cmdProgram(18'h00210, 8'h11, 1'b1);
    waitIdle();
    readExp(18'h00210, 8'h11, "R4 program sector1");

    // R6: erase of sector 1 spares sector 0
    cmdErase(18'h003FF);
    waitIdle();
    readExp(18'h00210, 8'hFF, "R6 sector1 cleared");
    readExp(18'h00010, 8'h30, "R6 sector0 kept");

    // R13: aliasing of sector numbers
    readExp(18'h00810, 8'h30, "R13 alias 00810");
    readExp(18'h3C010, 8'h30, "R13 alias 3C010");

    // R7: boot lock
    lockBoot = 1'b1;
    runsBefore = busyRuns;
    cmdProgram(18'h3C020, 8'h00, 1'b0);
    waitIdle();
    chk("R7 locked program no busy", busyRuns, runsBefore);
    readExp(18'h00020, 8'hFF, "R7 locked program dropped");
    cmdErase(18'h3C000);
    waitIdle();
    chk("R7 locked erase no busy", busyRuns, runsBefore);
    readExp(18'h00010, 8'h30, "R7 locked erase dropped");
    cmdProgram(18'h00030, 8'h0F, 1'b0);
    waitIdle();
    readExp(18'h00030, 8'h0F, "R7 outside region accepted");
    lockBoot = 1'b0;
    cmdProgram(18'h3C020, 8'h77, 1'b1);
    waitIdle();
    readExp(18'h00020, 8'h77, "R7 unlocked boot program");

    // R8: non-matching write abandons a sequence
    busWrite(18'h05555, 8'hAA, 1'b0);
    busWrite(18'h02AAA, 8'h55, 1'b0);
    busWrite(18'h05555, 8'hFF, 1'b0);
    busWrite(18'h05555, 8'hA0, 1'b0);
    busWrite(18'h00040, 8'h00, 1'b0);
    waitIdle();
    readExp(18'h00040, 8'hFF, "R8 FF write aborts");
    busWrite(18'h05555, 8'hAA, 1'b1);
    busWrite(18'h02AAA, 8'h00, 1'b1);
    busWrite(18'h02AAA, 8'h55, 1'b1);
    busWrite(18'h05555, 8'hA0, 1'b1);
    busWrite(18'h00050, 8'h00, 1'b1);
    waitIdle();
    readExp(18'h00050, 8'hFF, "R8 broken unlock aborts");

    // R9: a partial sequence waits indefinitely
    busWrite(18'h05555, 8'hAA, 1'b0);
    busWrite(18'h02AAA, 8'h55, 1'b0);
    repeat (300) @(negedge clk);
    busWrite(18'h05555, 8'hA0, 1'b0);
    repeat (300) @(negedge clk);
    busWrite(18'h00060, 8'h44, 1'b0);
    waitIdle();
    readExp(18'h00060, 8'h44, "R9 completes after idle");

    // R12: writes inside the erase window are dropped
    runsBefore = busyRuns;
    cmdErase(18'h00200);
    chk("R12 busy during window", busy, 1'b1);
    cmdProgram(18'h00080, 8'h00, 1'b0);
    chk("R12 still busy", busy, 1'b1);
    waitIdle();
    chk("R12 single window", busyRuns, runsBefore + 1);
    chk("R11 erase length again", lastRun, ERASE_LEN);
    readExp(18'h00080, 8'hFF, "R12 program in busy dropped");
    busWrite(18'h05555, 8'hA0, 1'b0);
    busWrite(18'h00090, 8'h00, 1'b0);
    waitIdle();
    readExp(18'h00090, 8'hFF, "R12 read mode after busy");

    // R2: no drive while write-enable is low
    @(negedge clk);
    addr = 18'h01234; dataIn = 8'h00; ceN = 1'b0; oeN = 1'b0; weN = 1'b0;
    repeat (2) @(negedge clk);
    chk("R2 no drive during write", dataOe, 1'b0);
    ceN = 1'b1; weN = 1'b1; oeN = 1'b1;
    repeat (6) @(negedge clk);
    readExp(18'h00030, 8'h0F, "R2 read stored byte");

    repeat (4) @(negedge clk);
    finishRun();
  end

endmodule